// File: doc/BRIEF.md
# Pseudorandom Bit-Error Receive Checker

This block checks a serial bit stream against one of five pseudorandom sequences. The sequence is chosen by a 3-bit select. The block has no fixed starting state. It fills a 20-stage reference shift register from the received bits until its own prediction agrees with the line for a long enough run. It then declares lock and runs the reference freely from its own predictions. From that point every accepted bit is compared with the predicted bit. Accepted bits and mismatching bits are counted.

The host controls the block through two level inputs, and only their rising edges act. A rising edge on the restart control drops lock and starts seeding again. A rising edge on the snapshot control does two things at the same clock edge: it copies the running bit and error counts into held outputs, and it starts a new counting period. Bits arrive on a valid/ready interface. The block never applies back-pressure: ready is high in every cycle after the first clock edge out of reset. A bit is consumed on each edge where valid and ready are both high, and a cycle with valid low is a gap that the block does not observe.

Top module: `bert_rx_checker`

## Requirements
- R1: `in_ready_o` is low during reset and high from the first clock edge after reset onward. A bit is taken only when `in_valid_i` and `in_ready_o` are both high, and cycles with `in_valid_i` low do not affect lock or counts.
- R2: The pattern select codes are 3'b000 = x^7+x^6+1, 3'b001 = x^11+x^9+1, 3'b010 = x^15+x^14+1, 3'b011 = x^20+x^17+1 (QRSS length), and 3'b111 = x^9+x^5+1. In each, a bit equals the XOR of the bits the two exponents earlier. Codes 3'b100, 3'b101 and 3'b110 never give lock, and they clear lock one cycle after they are applied.
- R3: While seeding, received bits go into the reference. `sync_o` rises after 32 consecutive accepted bits that each match the prediction, so it is never high within 31 bits of a restart. With an error-free stream it is always high within L+32 bits, where L is the sequence length.
- R4: While locked, 6 or more mismatches inside any 64 consecutive accepted bits clear `sync_o` at the edge that takes the sixth mismatch. Mismatches spaced 13 bits apart keep lock indefinitely.
- R5: When `rx_inv_i` is 1, each received bit is complemented before it is compared or seeded.
- R6: Bits and errors are counted only while `sync_o` is high.
- R7: A rising edge of `load_cnt_i` copies the running counts to `held_bits_o` and `held_errs_o` and restarts the counts. A bit taken in that same cycle counts toward the new period. Holding `load_cnt_i` high does not copy again.
- R8: Both running counts saturate at all-ones and do not wrap.
- R9: A rising edge of `resync_i` clears `sync_o` on the next edge and restarts seeding. Holding `resync_i` high does not restart again.
- R10: After reset, `sync_o` is 0 and both held counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Received bit is present |
| in_data_i | input | 1 | Received bit |
| in_ready_o | output | 1 | Block accepts a bit |
| pat_sel_i | input | 3 | Sequence select |
| rx_inv_i | input | 1 | Complement received data |
| resync_i | input | 1 | Restart seeding on rising edge |
| load_cnt_i | input | 1 | Snapshot and clear counts on rising edge |
| sync_o | output | 1 | Lock flag |
| held_bits_o | output | BCNT_W (32) | Bit count from the last snapshot |
| held_errs_o | output | ECNT_W (24) | Error count from the last snapshot |

## Verification
The bench builds the block with a 12-bit bit counter and a 4-bit error counter. With these widths, saturation at 4095 bits and at 15 errors is reached in a few thousand cycles instead of billions. The lock run of 32, the 64-bit window and the limit of 6 keep their default values. This lets the bench hit the exact edges of the loss rule: errors 13 bits apart keep lock, and errors 12 bits apart lose it on the sixth error. It also tests the 31-bit lower bound and the L+32 upper bound on lock for every sequence length.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  localparam int REF_W = 20;
  localparam int IDX_W = $clog2(REF_W);

  typedef enum logic {ST_SEEK = 1'b0, ST_LOCK = 1'b1} sync_st_e;

  typedef struct packed {
    logic [IDX_W-1:0] far_idx;   // index of the bit L places back
    logic [IDX_W-1:0] near_idx;  // index of the inner tap
    logic             valid;
  } taps_t;

  function automatic taps_t pat_taps(input logic [2:0] sel);
    taps_t t;
    t = '{far_idx: '0, near_idx: '0, valid: 1'b0};
    case (sel)
      3'b000: t = '{far_idx: IDX_W'(6),  near_idx: IDX_W'(5),  valid: 1'b1};
      3'b001: t = '{far_idx: IDX_W'(10), near_idx: IDX_W'(8),  valid: 1'b1};
      3'b010: t = '{far_idx: IDX_W'(14), near_idx: IDX_W'(13), valid: 1'b1};
      3'b011: t = '{far_idx: IDX_W'(19), near_idx: IDX_W'(16), valid: 1'b1};
      3'b111: t = '{far_idx: IDX_W'(8),  near_idx: IDX_W'(4),  valid: 1'b1};
      default: t = '{far_idx: '0, near_idx: '0, valid: 1'b0};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bert_rx_refgen.sv
module bert_rx_refgen
  import bert_rx_pkg::*;
#(
  parameter int W = REF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             seed_i,
  input  logic             rx_bit_i,
  input  logic [IDX_W-1:0] far_idx_i,
  input  logic [IDX_W-1:0] near_idx_i,
  output logic             pred_o
);

  logic [W-1:0] ref_q;

  // ref_q[0] holds the newest bit of the sequence
  always_comb pred_o = ref_q[far_idx_i] ^ ref_q[near_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
    end else if (shift_i) begin
      ref_q <= {ref_q[W-2:0], (seed_i ? rx_bit_i : pred_o)};
    end
  end

endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
  import bert_rx_pkg::*;
#(
  parameter int SYNC_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic mism_i,
  input  logic pat_ok_i,
  input  logic restart_i,
  output logic locked_o
);

  localparam int RUN_W = $clog2(SYNC_RUN + 1);
  localparam int WC_W  = $clog2(WIN + 1);

  sync_st_e         st_q;
  logic [RUN_W-1:0] run_q;
  logic [WIN-1:0]   hist_q;
  logic [WC_W-1:0]  wcnt_q;
  logic [WC_W-1:0]  wnext;

  // sliding count of mismatches over the last WIN bits
  always_comb wnext = wcnt_q + WC_W'(mism_i) - WC_W'(hist_q[WIN-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEEK;
      run_q  <= '0;
      hist_q <= '0;
      wcnt_q <= '0;
    end else if (restart_i || !pat_ok_i) begin
      st_q   <= ST_SEEK;
      run_q  <= '0;
      hist_q <= '0;
      wcnt_q <= '0;
    end else if (bit_i) begin
      unique case (st_q)
        ST_SEEK: begin
          if (mism_i) begin
            run_q <= '0;
          end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
            st_q   <= ST_LOCK;
            run_q  <= '0;
            hist_q <= '0;
            wcnt_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
        ST_LOCK: begin
          hist_q <= {hist_q[WIN-2:0], mism_i};
          wcnt_q <= wnext;
          if (wnext >= WC_W'(ERR_LIMIT)) begin
            st_q  <= ST_SEEK;
            run_q <= '0;
          end
        end
        default: st_q <= ST_SEEK;
      endcase
    end
  end

  assign locked_o = (st_q == ST_LOCK);

endmodule

// File: rtl/bert_rx_counters.sv
module bert_rx_counters #(
  parameter int BCNT_W = 32,
  parameter int ECNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_i,
  input  logic              err_i,
  input  logic              load_i,
  output logic [BCNT_W-1:0] run_bits_o,
  output logic [ECNT_W-1:0] run_errs_o,
  output logic [BCNT_W-1:0] held_bits_o,
  output logic [ECNT_W-1:0] held_errs_o
);

  localparam logic [BCNT_W-1:0] BMAX = '1;
  localparam logic [ECNT_W-1:0] EMAX = '1;

  logic add_err;
  assign add_err = count_i & err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_bits_o  <= '0;
      run_errs_o  <= '0;
      held_bits_o <= '0;
      held_errs_o <= '0;
    end else if (load_i) begin
      held_bits_o <= run_bits_o;
      held_errs_o <= run_errs_o;
      run_bits_o  <= BCNT_W'(count_i);
      run_errs_o  <= ECNT_W'(add_err);
    end else begin
      if (count_i && run_bits_o != BMAX) run_bits_o <= run_bits_o + 1'b1;
      if (add_err && run_errs_o != EMAX) run_errs_o <= run_errs_o + 1'b1;
    end
  end

endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
  import bert_rx_pkg::*;
#(
  parameter int BCNT_W    = 32,
  parameter int ECNT_W    = 24,
  parameter int SYNC_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_data_i,
  output logic              in_ready_o,
  input  logic [2:0]        pat_sel_i,
  input  logic              rx_inv_i,
  input  logic              resync_i,
  input  logic              load_cnt_i,
  output logic              sync_o,
  output logic [BCNT_W-1:0] held_bits_o,
  output logic [ECNT_W-1:0] held_errs_o
);

  logic        ready_q, resync_q, load_q;
  logic        accept, rx_bit, pred, mism;
  logic        resync_edge, load_edge, locked, count_en;
  taps_t       taps;
  logic [BCNT_W-1:0] run_bits;
  logic [ECNT_W-1:0] run_errs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      resync_q <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      ready_q  <= 1'b1;
      resync_q <= resync_i;
      load_q   <= load_cnt_i;
    end
  end

  assign in_ready_o  = ready_q;
  assign accept      = in_valid_i & ready_q;
  assign rx_bit      = in_data_i ^ rx_inv_i;
  assign taps        = pat_taps(pat_sel_i);
  assign resync_edge = resync_i & ~resync_q;
  assign load_edge   = load_cnt_i & ~load_q;
  assign mism        = rx_bit ^ pred;
  assign count_en    = accept & locked & ~resync_edge & taps.valid;

  bert_rx_refgen #(.W(REF_W)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (accept),
    .seed_i     (~locked),
    .rx_bit_i   (rx_bit),
    .far_idx_i  (taps.far_idx),
    .near_idx_i (taps.near_idx),
    .pred_o     (pred)
  );

  bert_rx_sync #(
    .SYNC_RUN  (SYNC_RUN),
    .WIN       (WIN),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (accept),
    .mism_i    (mism),
    .pat_ok_i  (taps.valid),
    .restart_i (resync_edge),
    .locked_o  (locked)
  );

  bert_rx_counters #(
    .BCNT_W (BCNT_W),
    .ECNT_W (ECNT_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (count_en),
    .err_i       (mism),
    .load_i      (load_edge),
    .run_bits_o  (run_bits),
    .run_errs_o  (run_errs),
    .held_bits_o (held_bits_o),
    .held_errs_o (held_errs_o)
  );

  assign sync_o = locked;

endmodule

// File: rtl/bert_rx_sva.sv
module bert_rx_sva #(
  parameter int BCNT_W = 32,
  parameter int ECNT_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              accept,
  input logic              mism,
  input logic              sync_o,
  input logic              resync_edge,
  input logic              load_edge,
  input logic              pat_ok,
  input logic [BCNT_W-1:0] run_bits,
  input logic [ECNT_W-1:0] run_errs,
  input logic [BCNT_W-1:0] held_bits_o,
  input logic [ECNT_W-1:0] held_errs_o
);

  // R3: lock can only rise after a bit was taken
  assert_lock_needs_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(accept));

  // R4: lock is lost only on a mismatch, a restart or a bad select
  assert_loss_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> $past((accept && mism) || resync_edge || !pat_ok));

  // R9: restart edge clears lock
  assert_restart_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_edge |=> !sync_o);

  // R2: unsupported select clears lock
  assert_bad_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_ok |=> !sync_o);

  // R7: held values move only after a snapshot edge
  assert_held_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(held_bits_o) && $stable(held_errs_o)) |-> $past(load_edge));

  // R6: no counting while unlocked
  assert_no_count_unlocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && !load_edge) |=> ($stable(run_bits) && $stable(run_errs)));

  // R8: saturated counts stay saturated until a snapshot
  assert_bits_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_bits == '1 && !load_edge) |=> run_bits == '1);

  assert_errs_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_errs == '1 && !load_edge) |=> run_errs == '1);

endmodule

bind bert_rx_checker bert_rx_sva #(.BCNT_W(BCNT_W), .ECNT_W(ECNT_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept      (accept),
  .mism        (mism),
  .sync_o      (sync_o),
  .resync_edge (resync_edge),
  .load_edge   (load_edge),
  .pat_ok      (taps.valid),
  .run_bits    (run_bits),
  .run_errs    (run_errs),
  .held_bits_o (held_bits_o),
  .held_errs_o (held_errs_o)
);

// File: tb/sim_bert_rx_checker.sv
module sim_bert_rx_checker;
  localparam int BW = 12;
  localparam int EW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 1'b0, in_data = 1'b0, in_ready;
  logic [2:0]    pat_sel = 3'b000;
  logic          rx_inv = 1'b0, resync = 1'b0, load_cnt = 1'b0;
  logic          sync;
  logic [BW-1:0] held_bits;
  logic [EW-1:0] held_errs;

  bert_rx_checker #(.BCNT_W(BW), .ECNT_W(EW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .pat_sel_i(pat_sel), .rx_inv_i(rx_inv),
    .resync_i(resync), .load_cnt_i(load_cnt), .sync_o(sync),
    .held_bits_o(held_bits), .held_errs_o(held_errs));

  int n_chk = 0, n_fail = 0;
  logic [63:0] gen = '1;
  int ga = 7, gb = 6;
  logic tx_inv = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic nxt();
    logic nb;
    nb  = gen[ga-1] ^ gen[gb-1];
    gen = {gen[62:0], nb};
    return nb;
  endfunction

  task automatic set_pat(input logic [2:0] code, input int a, input int b);
    pat_sel = code; ga = a; gb = b; gen = '1;
  endtask

  task automatic send(input logic b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic send_good(input int n);
    for (int i = 0; i < n; i++) send(nxt() ^ tx_inv);
  endtask

  task automatic send_bad();
    send(~nxt() ^ tx_inv);
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic pulse_resync();
    @(negedge clk); resync = 1'b1; @(posedge clk); #1; resync = 1'b0; idle();
  endtask

  task automatic snap();
    @(negedge clk); load_cnt = 1'b1; @(posedge clk); #1; load_cnt = 1'b0; idle();
  endtask

  task automatic snap_with_bit();
    @(negedge clk); load_cnt = 1'b1; in_valid = 1'b1; in_data = nxt() ^ tx_inv;
    @(posedge clk); #1; load_cnt = 1'b0; in_valid = 1'b0; idle();
  endtask

  task automatic acquire(input int len);
    pulse_resync();
    send_good(len + 32);
  endtask

  // R10, R1
  task automatic t_reset();
    check("R10 sync after reset", int'(sync), 0);
    check("R10 held bits after reset", int'(held_bits), 0);
    check("R10 held errs after reset", int'(held_errs), 0);
    check("R1 ready after reset", int'(in_ready), 1);
  endtask

  // R2, R3: lock bounds for each select code
  task automatic t_lock(input logic [2:0] code, input int a, input int b);
    set_pat(code, a, b);
    pulse_resync();
    send_good(31);
    check($sformatf("R3 no lock at 31 bits code %0d", code), int'(sync), 0);
    send_good(a + 1);
    check($sformatf("R2 lock within L+32 code %0d", code), int'(sync), 1);
  endtask

  // R2, R6: unsupported select, nothing counted
  task automatic t_unsupported();
    set_pat(3'b100, 7, 6);
    pulse_resync();
    snap();
    send_good(200);
    check("R2 no lock on code 100", int'(sync), 0);
    snap();
    check("R6 no bits counted unlocked", int'(held_bits), 0);
  endtask

  // R7, R4, R1: counting with sparse errors, gaps ignored
  task automatic t_count();
    set_pat(3'b000, 7, 6);
    acquire(7);
    snap();
    for (int i = 0; i < 100; i++) begin
      if (i == 20 || i == 50 || i == 80) send_bad(); else send_good(1);
      if (i == 60) begin idle(); idle(); end
    end
    check("R4 lock kept with 3 errors", int'(sync), 1);
    snap();
    check("R7 held bits 100", int'(held_bits), 100);
    check("R7 held errs 3", int'(held_errs), 3);
    check("R1 gap cycles not counted", int'(held_bits), 100);
  endtask

  // R7: same-cycle bit belongs to new period, level does not recopy
  task automatic t_snap_edge();
    snap();
    send_good(10);
    snap_with_bit();
    check("R7 snapshot before same-cycle bit", int'(held_bits), 10);
    send_good(5);
    snap();
    check("R7 same-cycle bit in new period", int'(held_bits), 6);
    @(negedge clk); load_cnt = 1'b1; @(posedge clk); #1;
    send_good(5);
    check("R7 level high does not recopy", int'(held_bits), 0);
    load_cnt = 1'b0; idle();
    snap();
    check("R7 bits while level high", int'(held_bits), 5);
  endtask

  // R4, R8: window edges and error saturation
  task automatic t_window();
    acquire(7);
    snap();
    for (int k = 0; k < 20; k++) begin send_bad(); send_good(12); end
    check("R4 spacing 13 keeps lock", int'(sync), 1);
    snap();
    check("R8 error count saturates", int'(held_errs), 15);
    acquire(7);
    for (int k = 0; k < 5; k++) begin send_bad(); send_good(11); end
    check("R4 five errors keep lock", int'(sync), 1);
    send_bad();
    check("R4 sixth error in window drops lock", int'(sync), 0);
  endtask

  // R8: bit count saturation
  task automatic t_bit_sat();
    acquire(7);
    snap();
    send_good(4200);
    snap();
    check("R8 bit count saturates", int'(held_bits), 4095);
  endtask

  // R5: receive complement
  task automatic t_invert();
    rx_inv = 1'b1; tx_inv = 1'b1;
    acquire(7);
    check("R5 lock on complemented stream", int'(sync), 1);
    snap();
    send_good(50);
    snap();
    check("R5 no errors on complemented stream", int'(held_errs), 0);
    tx_inv = 1'b0;
    send_good(5);
    check("R5 five flipped bits keep lock", int'(sync), 1);
    send_good(1);
    check("R5 uncomplemented stream loses lock", int'(sync), 0);
    rx_inv = 1'b0;
  endtask

  // R9: restart edge versus level
  task automatic t_resync();
    acquire(7);
    check("R9 locked before restart", int'(sync), 1);
    @(negedge clk); resync = 1'b1; @(posedge clk); #1;
    check("R9 restart edge drops lock", int'(sync), 0);
    send_good(7 + 32);
    send_good(50);
    check("R9 level high does not restart", int'(sync), 1);
    resync = 1'b0; idle();
    pulse_resync();
    check("R9 new edge drops lock", int'(sync), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();
    t_reset();
    t_lock(3'b000, 7, 6);
    t_lock(3'b001, 11, 9);
    t_lock(3'b010, 15, 14);
    t_lock(3'b011, 20, 17);
    t_lock(3'b111, 9, 5);
    t_unsupported();
    t_count();
    t_snap_edge();
    t_window();
    t_bit_sat();
    t_invert();
    t_resync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule